// File: doc/BRIEF.md
# Streaming Sort-Reduce Merge Tree

This block accepts a fixed number of key-value update streams, each already in ascending key order, and produces a single ascending stream. Records that carry the same key are folded into one record by an associative combine function. The fold happens inside every merge node, so each level of the tree passes on fewer records than it receives.

Every input and the output use a ready/valid handshake. A per-record last flag marks the final record of a stream. The combine function is picked by `mode_i`: wrap-around addition or unsigned minimum.

The tree is built from 2-to-1 merge nodes, with a small FIFO after each node. A node compares the head keys of its two inputs and takes the smaller one. On a tie it takes input 0 first. It keeps one pending record and folds any record with the same key into it. It sends the pending record on when a larger key is selected, or when both of its inputs have ended.

Usage rules:
- Every input stream must carry at least one record.
- `mode_i` is held constant from reset release until the output's last record.
- A new batch starts after a reset.

Top module: `sort_reduce_tree`

## Requirements
- R1: Output keys are strictly ascending. Every key that appears on any input appears exactly once at the output.
- R2: With `mode_i` = 0, an output value is the sum, modulo 2^32, of all input values with that key.
- R3: With `mode_i` = 1, an output value is the unsigned minimum of all input values with that key.
- R4: `out_last_o` is high on the final output record only. After that record is accepted, `out_valid_o` stays low until the next reset.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and the key, value and last outputs hold their values.
- R6: Once the record with the last flag has been accepted on an input, that input's ready bit stays low until reset.
- R7: After reset, with no input valid, `out_valid_o` is 0 and every bit of `in_ready_o` is 0.
- R8: When every record on every input has the same key, the output is exactly one record, with that key and `out_last_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Combine select: 0 = add, 1 = unsigned minimum |
| in_valid_i | input | N_IN | Per-stream record valid |
| in_ready_o | output | N_IN | Per-stream record accepted |
| in_key_i | input | N_IN*KEY_W | Keys, stream s at bits s*KEY_W upward |
| in_val_i | input | N_IN*VAL_W | Values, stream s at bits s*VAL_W upward |
| in_last_i | input | N_IN | Final record of the stream |
| out_valid_o | output | 1 | Output record valid |
| out_ready_i | input | 1 | Downstream accepts output |
| out_key_o | output | KEY_W | Output key |
| out_val_o | output | VAL_W | Reduced value |
| out_last_o | output | 1 | Final output record |

## Verification
The bench builds the block with its defaults: 16 inputs, 32-bit keys and values, and two-entry FIFOs. This gives a full four-level tree.

With all sixteen leaves active, duplicates are folded at each of the four levels. The streams also contain duplicates within a single stream. The shallow FIFOs fill quickly under random output stalls. This drives the hold and ready behaviour at every level.

Large random values make additions wrap past 2^32. Single-record streams and streams that all use one key exercise the end-of-stream flush through the whole depth of the tree.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic {
    CMB_ADD = 1'b0,
    CMB_MIN = 1'b1
  } cmb_e;
endpackage

// File: rtl/srm_fifo.sv
module srm_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_valid_i,
  output logic         push_ready_o,
  input  logic [W-1:0] push_data_i,
  output logic         pop_valid_o,
  input  logic         pop_ready_i,
  output logic [W-1:0] pop_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign push_ready_o = (cnt_q != CW'(DEPTH));
  assign pop_valid_o  = (cnt_q != '0);
  assign pop_data_o   = mem[rd_q];
  assign push = push_valid_i && push_ready_o;
  assign pop  = pop_valid_o && pop_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_q] <= push_data_i;
  end

  p_fifo_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o && !pop_ready_i |=> pop_valid_o && $stable(pop_data_o));
endmodule

// File: rtl/srm_merge_node.sv
module srm_merge_node
  import srm_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int VAL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmb_e             mode_i,
  input  logic             a_valid_i,
  output logic             a_ready_o,
  input  logic [KEY_W-1:0] a_key_i,
  input  logic [VAL_W-1:0] a_val_i,
  input  logic             a_last_i,
  input  logic             b_valid_i,
  output logic             b_ready_o,
  input  logic [KEY_W-1:0] b_key_i,
  input  logic [VAL_W-1:0] b_val_i,
  input  logic             b_last_i,
  output logic             o_valid_o,
  input  logic             o_ready_i,
  output logic [KEY_W-1:0] o_key_o,
  output logic [VAL_W-1:0] o_val_o,
  output logic             o_last_o
);
  logic             a_done_q, b_done_q, pend_v_q;
  logic [KEY_W-1:0] pend_key_q;
  logic [VAL_W-1:0] pend_val_q;
  logic             a_av, b_av, sel_v, sel_a, same, flush, take;
  logic [KEY_W-1:0] sel_key;
  logic [VAL_W-1:0] sel_val, fold_val;

  assign a_av  = a_valid_i && !a_done_q;
  assign b_av  = b_valid_i && !b_done_q;
  // a head is only final once the other side is known (valid or ended)
  assign sel_v = (a_av && (b_av || b_done_q)) || (b_av && a_done_q);
  assign sel_a = a_av && (b_done_q || !b_av || a_key_i <= b_key_i);
  assign sel_key = sel_a ? a_key_i : b_key_i;
  assign sel_val = sel_a ? a_val_i : b_val_i;

  assign same  = pend_v_q && (sel_key == pend_key_q);
  assign flush = a_done_q && b_done_q && pend_v_q;
  assign take  = sel_v && (!pend_v_q || same || o_ready_i);

  assign a_ready_o = take && sel_a;
  assign b_ready_o = take && !sel_a;

  assign o_valid_o = flush || (sel_v && pend_v_q && !same);
  assign o_key_o   = pend_key_q;
  assign o_val_o   = pend_val_q;
  assign o_last_o  = flush;

  always_comb begin
    if (mode_i == CMB_MIN) fold_val = (sel_val < pend_val_q) ? sel_val : pend_val_q;
    else                   fold_val = pend_val_q + sel_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_done_q   <= 1'b0;
      b_done_q   <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_key_q <= '0;
      pend_val_q <= '0;
    end else begin
      if (take) begin
        if (same) begin
          pend_val_q <= fold_val;
        end else begin
          pend_key_q <= sel_key;
          pend_val_q <= sel_val;
          pend_v_q   <= 1'b1;
        end
        if (sel_a && a_last_i)  a_done_q <= 1'b1;
        if (!sel_a && b_last_i) b_done_q <= 1'b1;
      end
      if (flush && o_ready_i) pend_v_q <= 1'b0;
    end
  end

  // checker state
  logic             prev_v_q, fin_q;
  logic [KEY_W-1:0] prev_key_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_v_q   <= 1'b0;
      fin_q      <= 1'b0;
      prev_key_q <= '0;
    end else if (o_valid_o && o_ready_i) begin
      prev_v_q   <= 1'b1;
      prev_key_q <= o_key_o;
      if (o_last_o) fin_q <= 1'b1;
    end
  end

  p_key_ascend_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_valid_o && prev_v_q |-> o_key_o > prev_key_q);
  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_valid_o && !o_ready_i |=> o_valid_o && $stable(o_key_o) && $stable(o_val_o) && $stable(o_last_o));
  p_quiet_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> !o_valid_o);
  p_ended_not_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_i && a_ready_o && a_last_i |=> !a_ready_o);
  p_min_fold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && same && mode_i == CMB_MIN |=> pend_val_q <= $past(pend_val_q));
endmodule

// File: rtl/sort_reduce_tree.sv
module sort_reduce_tree
  import srm_pkg::*;
#(
  parameter int N_IN       = 16,
  parameter int KEY_W      = 32,
  parameter int VAL_W      = 32,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [N_IN-1:0]        in_valid_i,
  output logic [N_IN-1:0]        in_ready_o,
  input  logic [N_IN*KEY_W-1:0]  in_key_i,
  input  logic [N_IN*VAL_W-1:0]  in_val_i,
  input  logic [N_IN-1:0]        in_last_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [KEY_W-1:0]       out_key_o,
  output logic [VAL_W-1:0]       out_val_o,
  output logic                   out_last_o
);
  localparam int LEVELS = $clog2(N_IN);
  localparam int RW     = 1 + KEY_W + VAL_W;

  // record layout: {last, key, val}
  logic          lv_valid [LEVELS+1][N_IN];
  logic          lv_ready [LEVELS+1][N_IN];
  logic [RW-1:0] lv_rec   [LEVELS+1][N_IN];
  cmb_e          mode;

  assign mode = cmb_e'(mode_i);

  for (genvar j = 0; j < N_IN; j++) begin : g_leaf
    assign lv_valid[0][j] = in_valid_i[j];
    assign lv_rec[0][j]   = {in_last_i[j], in_key_i[j*KEY_W +: KEY_W], in_val_i[j*VAL_W +: VAL_W]};
    assign in_ready_o[j]  = lv_ready[0][j];
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT = N_IN >> (l + 1);
    for (genvar j = 0; j < CNT; j++) begin : g_node
      logic             n_valid, n_ready, n_last;
      logic [KEY_W-1:0] n_key;
      logic [VAL_W-1:0] n_val;
      logic [RW-1:0]    ra, rb;
      assign ra = lv_rec[l][2*j];
      assign rb = lv_rec[l][2*j+1];

      srm_merge_node #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_node (
        .clk_i, .rst_ni, .mode_i(mode),
        .a_valid_i(lv_valid[l][2*j]),   .a_ready_o(lv_ready[l][2*j]),
        .a_key_i(ra[VAL_W +: KEY_W]),   .a_val_i(ra[VAL_W-1:0]), .a_last_i(ra[RW-1]),
        .b_valid_i(lv_valid[l][2*j+1]), .b_ready_o(lv_ready[l][2*j+1]),
        .b_key_i(rb[VAL_W +: KEY_W]),   .b_val_i(rb[VAL_W-1:0]), .b_last_i(rb[RW-1]),
        .o_valid_o(n_valid), .o_ready_i(n_ready),
        .o_key_o(n_key), .o_val_o(n_val), .o_last_o(n_last)
      );

      srm_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i, .rst_ni,
        .push_valid_i(n_valid), .push_ready_o(n_ready), .push_data_i({n_last, n_key, n_val}),
        .pop_valid_o(lv_valid[l+1][j]), .pop_ready_i(lv_ready[l+1][j]),
        .pop_data_o(lv_rec[l+1][j])
      );
    end
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_tie
    for (genvar j = (N_IN >> l); j < N_IN; j++) begin : g_unused
      assign lv_valid[l][j] = 1'b0;
      assign lv_rec[l][j]   = '0;
      if (!(l == LEVELS && j == 0)) begin : g_rdy
        assign lv_ready[l][j] = 1'b0;
      end
    end
  end

  assign lv_ready[LEVELS][0] = out_ready_i;
  assign out_valid_o = lv_valid[LEVELS][0];
  assign out_last_o  = lv_rec[LEVELS][0][RW-1];
  assign out_key_o   = lv_rec[LEVELS][0][VAL_W +: KEY_W];
  assign out_val_o   = lv_rec[LEVELS][0][VAL_W-1:0];
endmodule

// File: tb/sort_reduce_tree_test.sv
module sort_reduce_tree_test;
  localparam int NS = 16;
  localparam int ML = 48;
  localparam int WD = 20000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode = 1'b0;
  logic [NS-1:0]  in_valid = '0, in_last = '0;
  logic [NS-1:0]  in_ready;
  logic [NS*32-1:0] in_key = '0, in_val = '0;
  logic           out_valid, out_last;
  logic           out_ready = 1'b0;
  logic [31:0]    out_key, out_val;

  int n_chk = 0, n_fail = 0;
  logic [31:0] sk [NS][ML];
  logic [31:0] sv [NS][ML];
  int          slen [NS];

  always #10 clk = ~clk;

  sort_reduce_tree uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_key_i(in_key), .in_val_i(in_val),
    .in_last_i(in_last), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_key_o(out_key), .out_val_o(out_val), .out_last_o(out_last)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit m);
    in_valid = '0; in_last = '0; out_ready = 1'b0; mode = m;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic gen(int maxlen, int span, bit big, bit one_key);
    for (int s = 0; s < NS; s++) begin
      logic [31:0] k;
      slen[s] = 1 + int'($urandom % maxlen);
      k = one_key ? 32'd5 : $urandom % span;
      for (int i = 0; i < slen[s]; i++) begin
        sk[s][i] = k;
        sv[s][i] = big ? $urandom : ($urandom % 1000);
        if (!one_key) k = k + ($urandom % 3);
      end
    end
  endtask

  task automatic run(string name, bit m, int vprob, int rprob);
    logic [31:0] ref_v [logic [31:0]];
    logic [31:0] ek [$], ev [$], gk [$], gv [$];
    int  ptr [NS];
    bit  hs [NS];
    bit  ended [NS];
    bit  got_last = 0, stall = 0, extra_last = 0;
    int  v5 = 0, v6 = 0, quiet = 0, cyc = 0, mism = 0;
    logic [31:0] hk = '0, hv = '0;
    logic hl = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < slen[s]; i++) begin
        if (ref_v.exists(sk[s][i]))
          ref_v[sk[s][i]] = m ? ((sv[s][i] < ref_v[sk[s][i]]) ? sv[s][i] : ref_v[sk[s][i]])
                              : ref_v[sk[s][i]] + sv[s][i];
        else ref_v[sk[s][i]] = sv[s][i];
      end
    foreach (ref_v[k]) begin ek.push_back(k); ev.push_back(ref_v[k]); end
    for (int s = 0; s < NS; s++) begin ptr[s] = 0; hs[s] = 0; ended[s] = 0; end
    do_reset(m);
    while (cyc < WD && quiet < 20) begin
      @(negedge clk);
      cyc++;
      for (int s = 0; s < NS; s++) begin
        if (hs[s]) begin
          ptr[s]++;
          if (ptr[s] == slen[s]) ended[s] = 1;
        end
        if (!(in_valid[s] && !hs[s]))
          in_valid[s] = (ptr[s] < slen[s]) && (($urandom % 100) < vprob);
        if (ptr[s] < slen[s]) begin
          in_key[s*32 +: 32] = sk[s][ptr[s]];
          in_val[s*32 +: 32] = sv[s][ptr[s]];
          in_last[s] = (ptr[s] == slen[s] - 1);
        end
      end
      out_ready = got_last ? 1'b1 : (($urandom % 100) < rprob);
      #1;
      for (int s = 0; s < NS; s++) begin
        hs[s] = in_valid[s] && in_ready[s];
        if (ended[s] && in_ready[s]) v6++;
      end
      if (stall && !(out_valid && out_key == hk && out_val == hv && out_last == hl)) v5++;
      stall = out_valid && !out_ready;
      hk = out_key; hv = out_val; hl = out_last;
      if (got_last) begin
        quiet++;
        if (out_valid) extra_last = 1;
      end else if (out_valid && out_ready) begin
        gk.push_back(out_key); gv.push_back(out_val);
        if (out_last) got_last = 1;
      end
    end
    in_valid = '0;
    check(got_last, "R4", {name, " finished before watchdog"}, cyc, WD);
    check(gk.size() == ek.size(), "R1", {name, " record count"}, gk.size(), ek.size());
    for (int i = 0; i < gk.size() && i < ek.size(); i++) begin
      if (gk[i] != ek[i] || gv[i] != ev[i]) begin
        if (mism == 0)
          $display("FAIL %s %s record %0d: actual key %0d val %0d expected key %0d val %0d",
                   m ? "R3" : "R2", name, i, gk[i], gv[i], ek[i], ev[i]);
        mism++;
      end
    end
    n_chk++;
    if (mism != 0) n_fail++;
    check(!extra_last, "R4", {name, " output after last"}, extra_last, 0);
    check(v5 == 0, "R5", {name, " stall hold violations"}, v5, 0);
    check(v6 == 0, "R6", {name, " ready after stream end"}, v6, 0);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    check(in_ready == '0, "R7", "in_ready after reset", in_ready, 0);
  endtask

  task automatic t_add;       gen(ML, 40, 0, 0);  run("add_basic R1 R2", 0, 70, 80); endtask
  task automatic t_min;       gen(ML, 40, 1, 0);  run("min_mode R3", 1, 70, 80);      endtask
  task automatic t_wrap;      gen(20, 10, 1, 0);  run("add_wrap R2", 0, 90, 90);      endtask
  task automatic t_stall;     gen(30, 60, 0, 0);  run("backpressure R5 R6", 0, 40, 20); endtask
  task automatic t_single;    gen(1, 1000, 0, 0); run("single_record R4", 0, 60, 60); endtask

  task automatic t_one_key;
    gen(10, 1, 0, 1);
    run("one_key R8", 0, 80, 70);
    n_chk++;
    if (!(uut.out_valid_o == 1'b0)) begin n_fail++; $display("FAIL R8 one_key idle: actual 1 expected 0"); end
  endtask

  initial begin
    t_reset();
    t_add();
    t_min();
    t_wrap();
    t_stall();
    t_one_key();
    t_single();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule